// File: doc/BRIEF.md
# Low-Power Mode Controller

This block sequences a small microcontroller core through two reduced-power states. Software selects a state by writing a control word that carries an idle bit and a power-down bit. In idle the CPU clock is gated and the oscillator keeps running. In power-down the CPU clock is gated and the oscillator enable is dropped as well. In both states RAM and special function registers keep their contents, because the block only gates clocks.

Idle ends when an enabled interrupt is pending, or when the external hardware reset pin is raised. When reset ends idle, the core keeps running for a grace window of two machine cycles before the reset sequence starts. During that window the block raises an internal-RAM write inhibit, and port writes are left untouched. Power-down ends only on hardware reset. The block then restarts the oscillator and holds the CPU clock off until a programmable settle count of oscillator cycles has expired. After that it runs a special-function-register reset strobe.

The block runs on the free-running reference clock `clk`. `rst_n` is the power-on reset of the block itself. All outputs are decoded from one registered state, so each output responds one clock edge after the input that caused the change.

Top module: `lpm_ctrl`

## Requirements
- R1: After `rst_n` is released, the block is in run: `cpu_clk_en`=1, `osc_en`=1, `ram_wr_inhibit`=0, `sfr_rst`=0.
- R2: In run, with `hw_rst` low, a write (`ctl_wr`=1) with `ctl_idle`=1 and `ctl_pd`=0 enters idle one edge later: `cpu_clk_en`=0, `osc_en`=1, `ram_wr_inhibit`=0, `sfr_rst`=0.
- R3: In run, with `hw_rst` low, a write with `ctl_pd`=1 enters power-down one edge later: all four outputs are 0. This holds whatever the value of `ctl_idle`, so power-down has priority over idle.
- R4: In idle, with `hw_rst` low, the block returns to run one edge after a cycle in which `irq_req & irq_en` is non-zero. A request whose enable bit is 0 does not wake the block.
- R5: `hw_rst` sampled high in idle starts a grace window of exactly 2*MC_CLKS cycles. In that window `cpu_clk_en`=1, `ram_wr_inhibit`=1 and `sfr_rst`=0. The window is followed directly by `sfr_rst`=1 with the clock running.
- R6: In power-down, interrupts (enabled or not) and control writes have no effect. The outputs stay all 0 until `hw_rst` is sampled high.
- R7: `hw_rst` sampled high in power-down sets `osc_en`=1 and `sfr_rst`=1 one edge later. `cpu_clk_en` then stays 0 for max(`settle_cycles`,1) cycles. After that `cpu_clk_en` goes to 1 while `sfr_rst` stays 1 for at least one more cycle.
- R8: In run, `hw_rst` high gives `sfr_rst`=1 with the clock running, for as long as it is held. One edge after `hw_rst` is sampled low, the block is back in run with `sfr_rst`=0.
- R9: In idle, a control write has no effect. Only an interrupt or a reset changes the state.
- R10: `ram_wr_inhibit` is 1 only while `cpu_clk_en`=1 and `sfr_rst`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous power-on reset of the block, active low |
| hw_rst | input | 1 | External hardware reset pin, active high, sampled |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_idle | input | 1 | Idle request bit of the control word |
| ctl_pd | input | 1 | Power-down request bit of the control word |
| irq_req | input | NIRQ | Pending interrupt requests |
| irq_en | input | NIRQ | Per-source interrupt enables |
| settle_cycles | input | CW | Oscillator settle count used after power-down |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| osc_en | output | 1 | Oscillator enable |
| ram_wr_inhibit | output | 1 | Blocks internal RAM writes |
| sfr_rst | output | 1 | Special function register reset strobe |

## Verification
Every state drives its own combination of the four outputs, so a wrong state shows at the ports on the first sampled cycle after the edge that entered it. A miscounted grace window or settle count shows at a precise cycle: `ram_wr_inhibit` falls too early or too late, or `cpu_clk_en` returns out of step with the programmed count. A missed wake-up or an illegal exit from power-down shows one edge after the interrupt or write that caused it, as a clock enable that differs from the reference model.

// File: rtl/lpm_ctrl.sv
`timescale 1ns/1ps
module lpm_ctrl #(
  parameter int NIRQ    = 5,
  parameter int MC_CLKS = 12,
  parameter int CW      = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hw_rst,
  input  logic            ctl_wr,
  input  logic            ctl_idle,
  input  logic            ctl_pd,
  input  logic [NIRQ-1:0] irq_req,
  input  logic [NIRQ-1:0] irq_en,
  input  logic [CW-1:0]   settle_cycles,
  output logic            cpu_clk_en,
  output logic            osc_en,
  output logic            ram_wr_inhibit,
  output logic            sfr_rst
);
  localparam int GRACE = 2 * MC_CLKS;

  typedef enum logic [2:0] {
    S_RUN, S_RST, S_IDLE, S_GRACE, S_PD, S_SETTLE
  } st_t;

  st_t st, st_nx;
  logic [CW-1:0] cnt;

  wire wake = |(irq_req & irq_en);
  wire [CW-1:0] settle_lim = (settle_cycles == '0) ? CW'(1) : settle_cycles;
  wire grace_done  = (cnt == CW'(GRACE - 1));
  wire settle_done = (cnt == settle_lim - CW'(1));

  always_comb begin
    st_nx = st;
    unique case (st)
      S_RUN:    if (hw_rst) st_nx = S_RST;
                else if (ctl_wr && ctl_pd) st_nx = S_PD;
                else if (ctl_wr && ctl_idle) st_nx = S_IDLE;
      S_RST:    if (!hw_rst) st_nx = S_RUN;
      S_IDLE:   if (hw_rst) st_nx = S_GRACE;
                else if (wake) st_nx = S_RUN;
      S_GRACE:  if (grace_done) st_nx = S_RST;
      S_PD:     if (hw_rst) st_nx = S_SETTLE;
      S_SETTLE: if (settle_done) st_nx = S_RST;
      default:  st_nx = S_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_RUN;
      cnt <= '0;
    end else begin
      st  <= st_nx;
      cnt <= (st_nx != st) ? '0 : cnt + CW'(1);
    end
  end

  assign cpu_clk_en     = (st == S_RUN) || (st == S_RST) || (st == S_GRACE);
  assign osc_en         = (st != S_PD);
  assign ram_wr_inhibit = (st == S_GRACE);
  assign sfr_rst        = (st == S_RST) || (st == S_SETTLE);
endmodule

// File: rtl/lpm_ctrl_chk.sv
`timescale 1ns/1ps
module lpm_ctrl_chk #(
  parameter int NIRQ    = 5,
  parameter int MC_CLKS = 12,
  parameter int CW      = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            hw_rst,
  input logic            ctl_wr,
  input logic            ctl_pd,
  input logic [NIRQ-1:0] irq_req,
  input logic [NIRQ-1:0] irq_en,
  input logic            cpu_clk_en,
  input logic            osc_en,
  input logic            ram_wr_inhibit,
  input logic            sfr_rst
);
  localparam int GRACE = 2 * MC_CLKS;

  logic inh_q;
  int   inh_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inh_q   <= 1'b0;
      inh_len <= 0;
    end else begin
      inh_q <= ram_wr_inhibit;
      if (ram_wr_inhibit) inh_len <= inh_q ? inh_len + 1 : 1;
    end
  end

  wire in_idle = !cpu_clk_en && osc_en && !sfr_rst;
  wire in_pd   = !cpu_clk_en && !osc_en;

  // R3
  osc_off_gates_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> !cpu_clk_en && !sfr_rst && !ram_wr_inhibit);
  // R10
  inhibit_only_grace_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr_inhibit |-> cpu_clk_en && !sfr_rst);
  // R5
  grace_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ram_wr_inhibit) |-> sfr_rst && cpu_clk_en && inh_len == GRACE);
  // R5
  grace_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inh_len <= GRACE);
  // R6
  pd_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_pd && !hw_rst |=> in_pd);
  // R7
  pd_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_pd && hw_rst |=> osc_en && sfr_rst && !cpu_clk_en);
  // R4
  idle_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle && !hw_rst && |(irq_req & irq_en) |=> cpu_clk_en && !sfr_rst && !ram_wr_inhibit);
  // R5
  idle_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle && hw_rst |=> ram_wr_inhibit && cpu_clk_en);
  // R3
  pd_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en && osc_en && !sfr_rst && !ram_wr_inhibit && !hw_rst && ctl_wr && ctl_pd |=> in_pd);
endmodule

bind lpm_ctrl lpm_ctrl_chk #(.NIRQ(NIRQ), .MC_CLKS(MC_CLKS), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .hw_rst(hw_rst), .ctl_wr(ctl_wr), .ctl_pd(ctl_pd),
  .irq_req(irq_req), .irq_en(irq_en), .cpu_clk_en(cpu_clk_en), .osc_en(osc_en),
  .ram_wr_inhibit(ram_wr_inhibit), .sfr_rst(sfr_rst)
);

// File: tb/lpm_ctrl_bench.sv
`timescale 1ns/1ps
module lpm_ctrl_bench;
  localparam int NIRQ = 5, MC_CLKS = 12, CW = 16, GRACE = 2 * MC_CLKS;

  logic clk = 1'b0, rst_n = 1'b0, hw_rst = 1'b0;
  logic ctl_wr = 1'b0, ctl_idle = 1'b0, ctl_pd = 1'b0;
  logic [NIRQ-1:0] irq_req = '0, irq_en = '0;
  logic [CW-1:0] settle_cycles = CW'(7);
  logic cpu_clk_en, osc_en, ram_wr_inhibit, sfr_rst;

  int vectors = 0, errors = 0;
  bit done = 1'b0;
  // reference model states: 0 run,1 reset,2 idle,3 grace,4 pd,5 settle
  int m_st = 0, m_cnt = 0;

  always #5 clk = ~clk;

  lpm_ctrl #(.NIRQ(NIRQ), .MC_CLKS(MC_CLKS), .CW(CW)) u_lpm_ctrl (
    .clk(clk), .rst_n(rst_n), .hw_rst(hw_rst), .ctl_wr(ctl_wr), .ctl_idle(ctl_idle),
    .ctl_pd(ctl_pd), .irq_req(irq_req), .irq_en(irq_en), .settle_cycles(settle_cycles),
    .cpu_clk_en(cpu_clk_en), .osc_en(osc_en), .ram_wr_inhibit(ram_wr_inhibit), .sfr_rst(sfr_rst)
  );

  function automatic logic [3:0] exp_out(int s);
    case (s)
      0: return 4'b1100;
      1: return 4'b1101;
      2: return 4'b0100;
      3: return 4'b1110;
      4: return 4'b0000;
      default: return 4'b0101;
    endcase
  endfunction

  function automatic int ref_next(int s, int c);
    int lim;
    lim = (settle_cycles == 0) ? 1 : int'(settle_cycles);
    case (s)
      0: return hw_rst ? 1 : (ctl_wr && ctl_pd) ? 4 : (ctl_wr && ctl_idle) ? 2 : 0;
      1: return hw_rst ? 1 : 0;
      2: return hw_rst ? 3 : (|(irq_req & irq_en)) ? 0 : 2;
      3: return (c == GRACE - 1) ? 1 : 3;
      4: return hw_rst ? 5 : 4;
      default: return (c == lim - 1) ? 1 : 5;
    endcase
  endfunction

  task automatic check(string req);
    logic [3:0] act, exp;
    act = {cpu_clk_en, osc_en, ram_wr_inhibit, sfr_rst};
    exp = exp_out(m_st);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: outputs {clk_en,osc,inh,sfr} = %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(string req);
    int nx;
    nx = ref_next(m_st, m_cnt);
    @(posedge clk);
    m_cnt = (nx != m_st) ? 0 : m_cnt + 1;
    m_st = nx;
    @(negedge clk);
    check(req);
  endtask

  task automatic wr(bit idle, bit pd, string req);
    ctl_wr = 1'b1; ctl_idle = idle; ctl_pd = pd;
    tick(req);
    ctl_wr = 1'b0; ctl_idle = 1'b0; ctl_pd = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: run incomplete, actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1");

    wr(1, 0, "R2");
    wr(0, 1, "R9");
    tick("R9");
    irq_req = 5'b00100; irq_en = 5'b11011;
    repeat (3) tick("R4 disabled irq");
    irq_en = 5'b00100;
    tick("R4");
    irq_req = '0;
    tick("R4");

    wr(1, 1, "R3");
    irq_req = '1; irq_en = '1;
    repeat (4) tick("R6 irq");
    irq_req = '0;
    wr(1, 0, "R6 write");
    settle_cycles = CW'(7);
    hw_rst = 1'b1; tick("R7"); hw_rst = 1'b0;
    repeat (9) tick("R7");

    settle_cycles = '0;
    wr(0, 1, "R3");
    hw_rst = 1'b1; tick("R7 zero"); hw_rst = 1'b0;
    repeat (3) tick("R7 zero");

    wr(1, 0, "R2");
    hw_rst = 1'b1; tick("R5");
    repeat (GRACE + 3) tick("R5");
    hw_rst = 1'b0;
    repeat (2) tick("R5");

    hw_rst = 1'b1;
    repeat (5) tick("R8");
    hw_rst = 1'b0;
    repeat (2) tick("R8");

    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      ctl_wr   = ($urandom % 6) == 0;
      ctl_idle = $urandom % 2;
      ctl_pd   = ($urandom % 3) == 0;
      irq_req  = ($urandom % 4 == 0) ? NIRQ'($urandom) : '0;
      irq_en   = NIRQ'($urandom);
      if ((i % 200) == 0) settle_cycles = CW'($urandom % 12);
      if (!hw_rst) hw_rst = ($urandom % 50) == 0;
      else hw_rst = ($urandom % 4) != 0;
      tick("R2/R4/R6/R10 random");
    end
    hw_rst = 1'b0; ctl_wr = 1'b0;
    repeat (40) tick("R8 drain");
    finish_run();
  end
endmodule